// File: doc/BRIEF.md
# Descrambler Lock Controller

This block sits on the receive side of a cell-based link, after cell delineation. It brings an additive descrambler into step with the far-end scrambler. It does this by predicting the keystream carried in the payload of idle cells, whose plaintext is all zeros. The block builds its keystream history from the received idle words. It predicts each following idle payload word from that history and counts the correct predictions. When the count reaches a programmable confidence value, it declares lock. From then on it removes the keystream from every payload word. Header words pass through untouched.

The block drives a receive loss-of-lock bit, which the surrounding logic places in the outgoing alarm/signaling byte. That bit is 1 from reset until the first lock and returns to 1 whenever lock is lost. A small transmit helper reads the same bit as reported by the far end and tells the local transmitter whether it must keep sending the scrambler sequence in its idle cells. Acquisition starts only once cell sync is present, and it does not wait for frame sync.

Top module: `descrambler_lock`

## Requirements
- R1: While `cellSync` is 0, no word is checked, `locked` is 0 and `rxLossBit` is 1 from the next clock edge, whatever words arrive.
- R2: The keystream follows x^31+x^28+1: each new bit is the XOR of the bits 31 and 28 positions earlier, and each 16-bit word carries 16 consecutive bits with the oldest bit in bit 15. An idle payload word equals the keystream. When acquisition starts, the first two idle payload words are loaded without being checked. `locked` rises after the idle payload word that completes `cfgLockCount` consecutive correct predictions.
- R3: Before lock, a failed prediction clears the count of correct predictions. The two idle payload words that follow it are loaded without being checked.
- R4: `rxLossBit` is 1 from reset, goes to 0 in the same cycle that `locked` rises, and otherwise equals the inverse of `locked`.
- R5: A cell begins with the word flagged by `cellStart`. Its first `HDR_WORDS` words (default 2) leave on `dataOut` unchanged, one cycle after they arrive.
- R6: Every other word leaves on `dataOut` one cycle later, XORed with the predicted keystream. After lock, the payload of a data cell is therefore delivered as its plaintext.
- R7: After lock, `cfgLossCount` consecutive failed idle predictions clear `locked`, set `rxLossBit` and restart acquisition. A correct prediction clears the run of failures.
- R8: Dropping `cellSync` while locked clears `locked` and sets `rxLossBit` at the next edge.
- R9: `txSeedOn` is 1 from reset. When `farLossValid` is 1, `txSeedOn` takes the value of `farLossBit` at the next edge. When `farLossValid` is 0, it holds its value.
- R10: Payload words of data cells (`idleCell` = 0) neither add to nor clear the count of correct predictions during acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cellSync | input | 1 | Cell delineation is in sync |
| cellStart | input | 1 | Current word is the first word of a cell |
| idleCell | input | 1 | Current cell is an idle cell |
| wordValid | input | 1 | `rxWord` holds a received word this cycle |
| rxWord | input | 16 | Received word |
| cfgLockCount | input | LOCK_CNT_W | Correct predictions needed for lock |
| cfgLossCount | input | LOSS_CNT_W | Consecutive failed predictions that drop lock |
| farLossValid | input | 1 | A far-end signaling byte has been received |
| farLossBit | input | 1 | Far-end receive loss-of-lock bit |
| dataOut | output | 16 | Descrambled word, or a header word passed through |
| dataOutValid | output | 1 | `dataOut` is valid |
| locked | output | 1 | Descrambler is locked |
| rxLossBit | output | 1 | Local loss-of-lock bit for the outgoing signaling byte |
| txSeedOn | output | 1 | Transmitter must place the scrambler sequence in idle cells |

## Verification
The lock search is driven with an unbroken run of idle cells. This pins the exact word on which lock appears, so a missing load phase or an off-by-one threshold shows up. A run with a single corrupted word before lock tells apart a design that resets its count and reloads from one that merely skips the bad word. Runs after lock with isolated and then consecutive corrupted words separate the reset of the failure run from the loss threshold itself. A data cell placed in the middle of acquisition, with a threshold larger than one cell, shows whether data words are wrongly counted or wrongly reset the count.

// File: rtl/dscr_pkg.sv
package dscr_pkg;
  localparam int WORD_W   = 16;
  localparam int LFSR_LEN = 31;
  localparam int LFSR_TAP = 28;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_ACQ  = 2'd1,
    ST_LOCK = 2'd2
  } lockState_t;

  typedef struct packed {
    logic clearHist;
    logic loadHist;
    logic advHist;
    logic passHeader;
    logic emit;
  } dpStrobe_t;

  // Next WORD_W keystream bits from a history whose bit 0 is the newest bit.
  function automatic logic [WORD_W-1:0] predictWord(input logic [LFSR_LEN-1:0] hist);
    logic [LFSR_LEN-1:0] walk;
    logic [WORD_W-1:0]   word;
    logic                nextBit;
    walk = hist;
    word = '0;
    for (int i = 0; i < WORD_W; i++) begin
      nextBit = walk[LFSR_LEN-1] ^ walk[LFSR_TAP-1];
      word[WORD_W-1-i] = nextBit;
      walk = {walk[LFSR_LEN-2:0], nextBit};
    end
    return word;
  endfunction
endpackage

// File: rtl/dscr_datapath.sv
module dscr_datapath
  import dscr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] rxWord,
  output logic              predOk,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOutValid
);
  localparam int KEEP_W = LFSR_LEN - WORD_W;

  logic [LFSR_LEN-1:0] hist;
  logic [WORD_W-1:0]   keyWord;

  always_comb begin
    keyWord = predictWord(hist);
    predOk  = (keyWord == rxWord);
  end

  // History shifts by one word: either the received bits or the predicted ones.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist <= '0;
    end else if (strobe.clearHist) begin
      hist <= '0;
    end else if (strobe.loadHist) begin
      hist <= {hist[KEEP_W-1:0], rxWord};
    end else if (strobe.advHist) begin
      hist <= {hist[KEEP_W-1:0], keyWord};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut      <= '0;
      dataOutValid <= 1'b0;
    end else begin
      dataOutValid <= strobe.emit;
      if (strobe.emit) begin
        dataOut <= strobe.passHeader ? rxWord : (rxWord ^ keyWord);
      end
    end
  end
endmodule

// File: rtl/dscr_control.sv
module dscr_control
  import dscr_pkg::*;
#(
  parameter int HDR_WORDS  = 2,
  parameter int CELL_WORDS = 34,
  parameter int LOCK_CNT_W = 6,
  parameter int LOSS_CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cellSync,
  input  logic                  cellStart,
  input  logic                  idleCell,
  input  logic                  wordValid,
  input  logic [LOCK_CNT_W-1:0] cfgLockCount,
  input  logic [LOSS_CNT_W-1:0] cfgLossCount,
  input  logic                  farLossValid,
  input  logic                  farLossBit,
  input  logic                  predOk,
  output dpStrobe_t             strobe,
  output logic                  locked,
  output logic                  rxLossBit,
  output logic                  txSeedOn
);
  localparam int POS_W = $clog2(CELL_WORDS + 1);
  localparam logic [POS_W-1:0] HDR_POS  = POS_W'(HDR_WORDS);
  localparam logic [POS_W-1:0] CELL_POS = POS_W'(CELL_WORDS);
  localparam int FILL_WORDS = 2;

  lockState_t            state;
  logic [POS_W-1:0]      wordPos;
  logic [POS_W-1:0]      posNow;
  logic [1:0]            fill;
  logic [LOCK_CNT_W-1:0] matchCnt;
  logic [LOSS_CNT_W-1:0] missCnt;
  logic                  isHeader;
  logic                  payloadWord;
  logic                  idlePayload;
  logic                  fillDone;
  logic                  lockHit;
  logic                  lossHit;

  always_comb begin
    posNow      = cellStart ? '0 : wordPos;
    isHeader    = posNow < HDR_POS;
    payloadWord = wordValid && cellSync && !isHeader;
    idlePayload = payloadWord && idleCell;
    fillDone    = (fill == 2'(FILL_WORDS));
    lockHit     = ({1'b0, matchCnt} + 1'b1) >= {1'b0, cfgLockCount};
    lossHit     = ({1'b0, missCnt} + 1'b1) >= {1'b0, cfgLossCount};
  end

  always_comb begin
    strobe            = '0;
    strobe.emit       = wordValid;
    strobe.passHeader = isHeader;
    unique case (state)
      ST_HUNT: strobe.clearHist = cellSync;
      ST_ACQ: begin
        if (idlePayload)      strobe.loadHist = 1'b1;
        else if (payloadWord) strobe.advHist  = 1'b1;
      end
      ST_LOCK: begin
        if (idlePayload && !predOk && lossHit) strobe.clearHist = 1'b1;
        else if (payloadWord)                  strobe.advHist   = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

  // Position of the current word inside its cell.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordPos <= HDR_POS;
    end else if (wordValid) begin
      wordPos <= (posNow < CELL_POS) ? posNow + 1'b1 : posNow;
    end
  end

  // Transmit helper: keep sending the seed sequence until the far end locks.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSeedOn <= 1'b1;
    end else if (farLossValid) begin
      txSeedOn <= farLossBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_HUNT;
      fill      <= '0;
      matchCnt  <= '0;
      missCnt   <= '0;
      rxLossBit <= 1'b1;
    end else if (!cellSync) begin
      state     <= ST_HUNT;
      fill      <= '0;
      matchCnt  <= '0;
      missCnt   <= '0;
      rxLossBit <= 1'b1;
    end else begin
      unique case (state)
        ST_HUNT: begin
          state    <= ST_ACQ;
          fill     <= '0;
          matchCnt <= '0;
        end
        ST_ACQ: begin
          if (idlePayload) begin
            if (!fillDone) begin
              fill <= fill + 1'b1;
            end else if (predOk) begin
              if (lockHit) begin
                state     <= ST_LOCK;
                rxLossBit <= 1'b0;
                matchCnt  <= '0;
                missCnt   <= '0;
              end else begin
                matchCnt <= matchCnt + 1'b1;
              end
            end else begin
              matchCnt <= '0;
              fill     <= '0;
            end
          end
        end
        ST_LOCK: begin
          if (idlePayload) begin
            if (predOk) begin
              missCnt <= '0;
            end else if (lossHit) begin
              state     <= ST_ACQ;
              rxLossBit <= 1'b1;
              fill      <= '0;
              matchCnt  <= '0;
              missCnt   <= '0;
            end else begin
              missCnt <= missCnt + 1'b1;
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  assign locked = (state == ST_LOCK);
endmodule

// File: rtl/descrambler_lock.sv
module descrambler_lock
  import dscr_pkg::*;
#(
  parameter int HDR_WORDS  = 2,
  parameter int CELL_WORDS = 34,
  parameter int LOCK_CNT_W = 6,
  parameter int LOSS_CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cellSync,
  input  logic                  cellStart,
  input  logic                  idleCell,
  input  logic                  wordValid,
  input  logic [15:0]           rxWord,
  input  logic [LOCK_CNT_W-1:0] cfgLockCount,
  input  logic [LOSS_CNT_W-1:0] cfgLossCount,
  input  logic                  farLossValid,
  input  logic                  farLossBit,
  output logic [15:0]           dataOut,
  output logic                  dataOutValid,
  output logic                  locked,
  output logic                  rxLossBit,
  output logic                  txSeedOn
);
  dpStrobe_t strobe;
  logic      predOk;

  dscr_control #(
    .HDR_WORDS (HDR_WORDS),
    .CELL_WORDS(CELL_WORDS),
    .LOCK_CNT_W(LOCK_CNT_W),
    .LOSS_CNT_W(LOSS_CNT_W)
  ) i_control (
    .clk         (clk),
    .rstN        (rstN),
    .cellSync    (cellSync),
    .cellStart   (cellStart),
    .idleCell    (idleCell),
    .wordValid   (wordValid),
    .cfgLockCount(cfgLockCount),
    .cfgLossCount(cfgLossCount),
    .farLossValid(farLossValid),
    .farLossBit  (farLossBit),
    .predOk      (predOk),
    .strobe      (strobe),
    .locked      (locked),
    .rxLossBit   (rxLossBit),
    .txSeedOn    (txSeedOn)
  );

  dscr_datapath i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rxWord      (rxWord),
    .predOk      (predOk),
    .dataOut     (dataOut),
    .dataOutValid(dataOutValid)
  );
endmodule

// File: rtl/descrambler_lock_checker.sv
module descrambler_lock_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cellSync,
  input logic        cellStart,
  input logic        idleCell,
  input logic        wordValid,
  input logic [15:0] rxWord,
  input logic        farLossValid,
  input logic        farLossBit,
  input logic [15:0] dataOut,
  input logic        dataOutValid,
  input logic        locked,
  input logic        rxLossBit,
  input logic        txSeedOn
);
  p_no_lock_without_sync_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cellSync |=> (!locked && rxLossBit));

  p_lock_from_idle_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(wordValid && idleCell && cellSync));

  p_loss_bit_tracks_lock_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxLossBit != locked);

  p_header_passes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && cellStart) |=> (dataOutValid && dataOut == $past(rxWord)));

  p_unlock_has_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(!cellSync || (wordValid && idleCell)));

  p_sync_drop_unlocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !cellSync) |=> !locked);

  p_seed_stops_r9: assert property (@(posedge clk) disable iff (!rstN)
    (farLossValid && !farLossBit) |=> !txSeedOn);

  p_seed_resumes_r9: assert property (@(posedge clk) disable iff (!rstN)
    (farLossValid && farLossBit) |=> txSeedOn);

  p_seed_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    !farLossValid |=> $stable(txSeedOn));
endmodule

bind descrambler_lock descrambler_lock_checker i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .cellSync    (cellSync),
  .cellStart   (cellStart),
  .idleCell    (idleCell),
  .wordValid   (wordValid),
  .rxWord      (rxWord),
  .farLossValid(farLossValid),
  .farLossBit  (farLossBit),
  .dataOut     (dataOut),
  .dataOutValid(dataOutValid),
  .locked      (locked),
  .rxLossBit   (rxLossBit),
  .txSeedOn    (txSeedOn)
);

// File: tb/test_descrambler_lock.sv
module test_descrambler_lock;
  localparam int PAYLOAD = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cellSync = 1'b0;
  logic        cellStart = 1'b0;
  logic        idleCell = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] rxWord = '0;
  logic [5:0]  cfgLockCount = 6'd8;
  logic [3:0]  cfgLossCount = 4'd3;
  logic        farLossValid = 1'b0;
  logic        farLossBit = 1'b0;
  logic [15:0] dataOut;
  logic        dataOutValid;
  logic        locked;
  logic        rxLossBit;
  logic        txSeedOn;

  int checks = 0;
  int errors = 0;
  bit summaryDone = 1'b0;
  logic [30:0] seqState = 31'h2B5C_13E7;
  logic [15:0] hdrCount = '0;

  always #10 clk = ~clk;

  descrambler_lock i_descrambler_lock (
    .clk(clk), .rstN(rstN), .cellSync(cellSync), .cellStart(cellStart),
    .idleCell(idleCell), .wordValid(wordValid), .rxWord(rxWord),
    .cfgLockCount(cfgLockCount), .cfgLossCount(cfgLossCount),
    .farLossValid(farLossValid), .farLossBit(farLossBit),
    .dataOut(dataOut), .dataOutValid(dataOutValid), .locked(locked),
    .rxLossBit(rxLossBit), .txSeedOn(txSeedOn)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Far-end keystream per R2: bit n = bit(n-31) ^ bit(n-28), oldest bit in bit 15.
  function automatic logic [15:0] nextKey();
    logic [15:0] w;
    logic b;
    for (int i = 0; i < 16; i++) begin
      b = seqState[30] ^ seqState[27];
      w[15-i] = b;
      seqState = {seqState[29:0], b};
    end
    return w;
  endfunction

  task automatic sendWord(input logic start, input logic idle, input logic [15:0] w);
    cellStart = start;
    idleCell  = idle;
    rxWord    = w;
    wordValid = 1'b1;
    @(negedge clk);
  endtask

  task automatic stopWords();
    wordValid = 1'b0;
    cellStart = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendHeaders(input logic idle, input string req);
    for (int h = 0; h < 2; h++) begin
      logic [15:0] hw;
      hw = 16'hC000 | hdrCount;
      hdrCount++;
      sendWord(h == 0, idle, hw);
      check(req, "header word passed unchanged (R5)", dataOut, hw);
    end
  endtask

  // Idle cell: flipMask bit k corrupts payload word k; expMask bit k is the expected lock after it.
  task automatic sendIdleCell(input logic [31:0] flipMask, input logic [31:0] expMask,
                              input bit doCheck, input string req);
    sendHeaders(1'b1, "R5");
    for (int k = 0; k < PAYLOAD; k++) begin
      logic [15:0] w;
      w = nextKey();
      if (flipMask[k]) w = w ^ 16'h0101;
      sendWord(1'b0, 1'b1, w);
      if (doCheck) begin
        check(req, $sformatf("locked after idle word %0d", k), locked, expMask[k]);
        check("R4", $sformatf("loss bit after idle word %0d", k), rxLossBit, !expMask[k]);
      end
    end
  endtask

  task automatic sendDataCell(input bit checkPlain, input logic expLock, input string req);
    sendHeaders(1'b0, "R5");
    for (int k = 0; k < PAYLOAD; k++) begin
      logic [15:0] plain;
      plain = 16'h1357 + 16'(k * 771);
      sendWord(1'b0, 1'b0, plain ^ nextKey());
      if (checkPlain) check("R6", $sformatf("descrambled data word %0d", k), dataOut, plain);
      check(req, $sformatf("lock during data word %0d", k), locked, expLock);
    end
  endtask

  task automatic testReset();
    check("R4", "loss bit at reset", rxLossBit, 1'b1);
    check("R2", "locked at reset", locked, 1'b0);
    check("R9", "seed enable at reset", txSeedOn, 1'b1);
    check("R6", "output valid at reset", dataOutValid, 1'b0);
  endtask

  task automatic testNoSync();
    cellSync = 1'b0;
    sendIdleCell(32'h0, 32'h0, 1'b1, "R1");
    sendIdleCell(32'h0, 32'h0, 1'b1, "R1");
    stopWords();
    check("R1", "still unlocked without sync", locked, 1'b0);
  endtask

  task automatic testAcquire();
    cfgLockCount = 6'd8;
    cellSync = 1'b1;
    @(negedge clk);
    // Two words loaded, then eight correct predictions: lock after idle word 9.
    sendIdleCell(32'h0, 32'hFFFF_FE00, 1'b1, "R2");
  endtask

  task automatic testDataAfterLock();
    sendDataCell(1'b1, 1'b1, "R6");
  endtask

  task automatic testLossAndRetry();
    cfgLossCount = 4'd3;
    // Words 0,1 fail (run reset by word 2), words 3..5 fail -> unlock after word 5 (R7).
    // Reacquire: words 6,7 load, 8..12 good, 13 fails, 14,15 load, 16..23 good -> lock at 23 (R3).
    sendIdleCell(32'h0000_203B, 32'hFF80_001F, 1'b1, "R7 R3");
  endtask

  task automatic testSyncDrop();
    stopWords();
    check("R8", "locked before sync drop", locked, 1'b1);
    cellSync = 1'b0;
    @(negedge clk);
    check("R8", "locked after sync drop", locked, 1'b0);
    check("R8", "loss bit after sync drop", rxLossBit, 1'b1);
  endtask

  task automatic testDataDuringAcq();
    cfgLockCount = 6'd40;
    cellSync = 1'b1;
    @(negedge clk);
    // 30 correct predictions, a data cell that must not change the count, then 10 more.
    sendIdleCell(32'h0, 32'h0, 1'b1, "R10");
    sendDataCell(1'b0, 1'b0, "R10");
    sendIdleCell(32'h0, 32'hFFFF_FE00, 1'b1, "R10");
    stopWords();
  endtask

  task automatic testSeedHandshake();
    check("R9", "seed on before far report", txSeedOn, 1'b1);
    farLossValid = 1'b1; farLossBit = 1'b1;
    @(negedge clk);
    check("R9", "seed on while far end unlocked", txSeedOn, 1'b1);
    farLossBit = 1'b0;
    @(negedge clk);
    check("R9", "seed off after far lock", txSeedOn, 1'b0);
    farLossValid = 1'b0; farLossBit = 1'b1;
    @(negedge clk);
    check("R9", "seed holds without valid", txSeedOn, 1'b0);
    farLossValid = 1'b1;
    @(negedge clk);
    check("R9", "seed on after far loss", txSeedOn, 1'b1);
    farLossValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNoSync();
    testAcquire();
    testDataAfterLock();
    testLossAndRetry();
    testSyncDrop();
    testDataDuringAcq();
    testSeedHandshake();
    finishRun();
  end
endmodule